// File: doc/BRIEF.md
# DSP Load/Store Address Generator

This block decodes the load/store instruction group of a small 16-bit DSP and turns each accepted instruction into one memory access request: a data-memory read, a data-memory write or an instruction-memory read. It forms the access address from one of four sources: a page byte joined to an 8-bit offset, a sign-extended 8-bit short address, a full address carried in a second instruction word, or one of four addressing registers. For the register-indirect forms it also reports the post-modified value of the addressing register: unchanged, minus one, plus one, or plus its paired index register taken as signed.

The register file and the memories sit outside. The block presents a source-register number for stores, receives that register's value in the same cycle, and reads the addressing, index and page registers from flat input buses. A load reports the destination register number, and the memory's return data is routed there outside the block. Two-word instructions hold the block in a wait state, flagged on `need_ext`, until the second word arrives on `ext_word` with `ext_valid`.

Top module: `ldst_agen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, all strobes (`dmem_re`, `dmem_we`, `imem_re`, `ld_we`, `ar_we`, `bad_op`) and `need_ext` are low.
- R2: Short form `0010 s rrr oooooooo`. s=0 is a data read into register 24+r. s=1 is a data write of register 24+r. The address is {page_lo, o}.
- R3: Long form `00000000 11 s ddddd`. s=0 loads register d and s=1 stores register d. The instruction is two words: `need_ext` rises in the cycle after acceptance and stays high, with no strobe, until `ext_valid`. The address is `ext_word`.
- R4: Store immediate `00010110 oooooooo` is two words. It writes `ext_word` to the address o sign-extended to 16 bits.
- R5: Indirect form `000110 s mm aa ddddd`. s=0 loads register d and s=1 stores register d. The address is the value of addressing register aa from before the update.
- R6: Post-modify code mm: 00 leaves the register alone (no `ar_we`), 01 subtracts one, 10 adds one, 11 adds index register aa. `ar_we` pulses with `ar_idx`=aa and `ar_next` holding the new value.
- R7: The index register is added as a signed 16-bit value, and all address arithmetic wraps modulo 2^16.
- R8: Instruction-memory load `0000001 d 0001 mm aa` raises `imem_re` at the address in register aa. The destination is register 30+d. The mm field has the same meaning as in R6.
- R9: Any other opcode raises only `bad_op`, with no memory strobe, no `ld_we` and no `ar_we`.
- R10: Results appear as single-cycle registered pulses one clock after the accepting edge. `op_valid` is ignored while `need_ext` is high. Unused result fields (`mem_addr`, `mem_wdata`, `ld_reg`, `ar_idx`, `ar_next`) read zero.
- R11: A store's write data is `src_data`, sampled in the accepting cycle. `src_sel` names the source register combinationally from the instruction being accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | First instruction word valid |
| op_word | input | 16 | First instruction word |
| ext_valid | input | 1 | Second word valid |
| ext_word | input | DW | Second word (address or immediate) |
| page_lo | input | DW/2 | Low byte of the page register |
| ar_bus | input | NAR*DW | Addressing registers, register 0 in the low bits |
| ix_bus | input | NAR*DW | Index registers, same packing |
| src_sel | output | 5 | Store source register number |
| src_data | input | DW | Value of register `src_sel` |
| need_ext | output | 1 | Waiting for the second word |
| mem_addr | output | DW | Access address |
| mem_wdata | output | DW | Write data |
| dmem_re | output | 1 | Data-memory read strobe |
| dmem_we | output | 1 | Data-memory write strobe |
| imem_re | output | 1 | Instruction-memory read strobe |
| ld_we | output | 1 | Load destination valid |
| ld_reg | output | 5 | Load destination register |
| ar_we | output | 1 | Addressing register update |
| ar_idx | output | $clog2(NAR) | Updated register number |
| ar_next | output | DW | New addressing register value |
| bad_op | output | 1 | Unhandled opcode pulse |

## Verification
The bound checker watches, on every cycle, that at most one access strobe or `bad_op` is raised at a time. It also checks that updates and load destinations only accompany a real access, that the wait for a second word emits nothing and ends right after `ext_valid`, and that an idle cycle yields no pulse. The exact address, data, destination and post-modified register value for each encoding can only be shown by the bench's scenarios. These scenarios cover page joining, sign extension, decrement and increment wrapping, negative index steps and stalls on the second word, and they compare every field against an independent model, also over randomized opcodes and register contents.

// File: rtl/ldst_agen_pkg.sv
package ldst_agen_pkg;
  localparam int OPW  = 16;
  localparam int REGW = 5;

  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_SHORT = 3'd1,
    K_LONG  = 3'd2,
    K_IMM   = 3'd3,
    K_IND   = 3'd4,
    K_IMEM  = 3'd5
  } kind_e;

  typedef struct packed {
    kind_e            kind;
    logic             store;
    logic             two;
    logic [REGW-1:0]  rnum;
    logic [1:0]       ar;
    logic [1:0]       mode;
    logic [7:0]       imm;
  } dec_t;
endpackage

// File: rtl/ldst_decode.sv
module ldst_decode
  import ldst_agen_pkg::*;
(
  input  logic [OPW-1:0] op,
  output dec_t           dec
);
  always_comb begin
    dec = '0;
    if (op[15:12] == 4'b0010) begin
      dec.kind  = K_SHORT;
      dec.store = op[11];
      dec.rnum  = {2'b11, op[10:8]};
      dec.imm   = op[7:0];
    end else if (op[15:6] == 10'b0000_0000_11) begin
      dec.kind  = K_LONG;
      dec.store = op[5];
      dec.two   = 1'b1;
      dec.rnum  = op[4:0];
    end else if (op[15:8] == 8'h16) begin
      dec.kind  = K_IMM;
      dec.store = 1'b1;
      dec.two   = 1'b1;
      dec.imm   = op[7:0];
    end else if (op[15:10] == 6'b000110) begin
      dec.kind  = K_IND;
      dec.store = op[9];
      dec.mode  = op[8:7];
      dec.ar    = op[6:5];
      dec.rnum  = op[4:0];
    end else if (op[15:9] == 7'b0000001 && op[7:4] == 4'b0001) begin
      dec.kind  = K_IMEM;
      dec.rnum  = {4'b1111, op[8]};
      dec.mode  = op[3:2];
      dec.ar    = op[1:0];
    end
  end
endmodule

// File: rtl/ldst_postmod.sv
module ldst_postmod #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] step,
  input  logic [1:0]    mode,
  output logic [DW-1:0] next_val,
  output logic          moved
);
  always_comb begin
    moved = 1'b1;
    unique case (mode)
      2'b01:   next_val = base - DW'(1);
      2'b10:   next_val = base + DW'(1);
      2'b11:   next_val = base + step;
      default: begin next_val = base; moved = 1'b0; end
    endcase
  end
endmodule

// File: rtl/ldst_agen.sv
module ldst_agen
  import ldst_agen_pkg::*;
#(
  parameter  int DW  = 16,
  parameter  int NAR = 4,
  localparam int ARW = $clog2(NAR),
  localparam int PGW = DW / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [OPW-1:0]    op_word,
  input  logic              ext_valid,
  input  logic [DW-1:0]     ext_word,
  input  logic [PGW-1:0]    page_lo,
  input  logic [NAR*DW-1:0] ar_bus,
  input  logic [NAR*DW-1:0] ix_bus,
  output logic [REGW-1:0]   src_sel,
  input  logic [DW-1:0]     src_data,
  output logic              need_ext,
  output logic [DW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic              dmem_re,
  output logic              dmem_we,
  output logic              imem_re,
  output logic              ld_we,
  output logic [REGW-1:0]   ld_reg,
  output logic              ar_we,
  output logic [ARW-1:0]    ar_idx,
  output logic [DW-1:0]     ar_next,
  output logic              bad_op
);
  logic [DW-1:0] ar_arr [NAR];
  logic [DW-1:0] ix_arr [NAR];

  for (genvar g = 0; g < NAR; g++) begin : g_unpack
    assign ar_arr[g] = ar_bus[g*DW +: DW];
    assign ix_arr[g] = ix_bus[g*DW +: DW];
  end

  logic           waiting;
  logic [OPW-1:0] held_op;
  logic [OPW-1:0] cur_op;
  dec_t           dec;

  assign cur_op = waiting ? held_op : op_word;

  ldst_decode u_dec (.op(cur_op), .dec(dec));

  logic [DW-1:0] ar_cur, ix_cur, ar_mod;
  logic          ar_moved;

  assign ar_cur = ar_arr[dec.ar[ARW-1:0]];
  assign ix_cur = ix_arr[dec.ar[ARW-1:0]];

  ldst_postmod #(.DW(DW)) u_pm (
    .base(ar_cur), .step(ix_cur), .mode(dec.mode),
    .next_val(ar_mod), .moved(ar_moved)
  );

  logic accept, start_wait, fire;
  assign accept     = !waiting && op_valid;
  assign start_wait = accept && dec.two;
  assign fire       = (accept && !dec.two) || (waiting && ext_valid);

  assign src_sel = dec.rnum;

  logic            n_dre, n_dwe, n_ire, n_bad, n_ldwe, n_arwe;
  logic [REGW-1:0] n_ldreg;
  logic [ARW-1:0]  n_aridx;
  logic [DW-1:0]   n_arnext, n_addr, n_wd;

  always_comb begin
    n_dre = 1'b0; n_dwe = 1'b0; n_ire = 1'b0; n_bad = 1'b0;
    n_ldwe = 1'b0; n_arwe = 1'b0; n_ldreg = '0; n_aridx = '0;
    n_arnext = '0; n_addr = '0; n_wd = '0;
    if (fire) begin
      unique case (dec.kind)
        K_SHORT: n_addr = DW'({page_lo, dec.imm});
        K_LONG:  n_addr = ext_word;
        K_IMM:   n_addr = {{(DW-8){dec.imm[7]}}, dec.imm};
        K_IND,
        K_IMEM:  n_addr = ar_cur;
        default: n_addr = '0;
      endcase
      case (dec.kind)
        K_SHORT, K_LONG, K_IND: begin
          n_dre = !dec.store;
          n_dwe = dec.store;
          n_ldwe = !dec.store;
          if (dec.store) n_wd = src_data;
          else           n_ldreg = dec.rnum;
        end
        K_IMM: begin
          n_dwe = 1'b1;
          n_wd  = ext_word;
        end
        K_IMEM: begin
          n_ire   = 1'b1;
          n_ldwe  = 1'b1;
          n_ldreg = dec.rnum;
        end
        default: begin
          n_bad  = 1'b1;
          n_addr = '0;
        end
      endcase
      if ((dec.kind == K_IND || dec.kind == K_IMEM) && ar_moved) begin
        n_arwe   = 1'b1;
        n_aridx  = dec.ar[ARW-1:0];
        n_arnext = ar_mod;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      waiting  <= 1'b0;
      held_op  <= '0;
      dmem_re  <= 1'b0;
      dmem_we  <= 1'b0;
      imem_re  <= 1'b0;
      bad_op   <= 1'b0;
      ld_we    <= 1'b0;
      ld_reg   <= '0;
      ar_we    <= 1'b0;
      ar_idx   <= '0;
      ar_next  <= '0;
      mem_addr <= '0;
      mem_wdata<= '0;
    end else begin
      if (start_wait) begin
        waiting <= 1'b1;
        held_op <= op_word;
      end else if (waiting && ext_valid) begin
        waiting <= 1'b0;
      end
      dmem_re   <= n_dre;
      dmem_we   <= n_dwe;
      imem_re   <= n_ire;
      bad_op    <= n_bad;
      ld_we     <= n_ldwe;
      ld_reg    <= n_ldreg;
      ar_we     <= n_arwe;
      ar_idx    <= n_aridx;
      ar_next   <= n_arnext;
      mem_addr  <= n_addr;
      mem_wdata <= n_wd;
    end
  end

  assign need_ext = waiting;
endmodule

// File: rtl/ldst_agen_chk.sv
module ldst_agen_chk (
  input logic clk,
  input logic rst,
  input logic op_valid,
  input logic ext_valid,
  input logic need_ext,
  input logic dmem_re,
  input logic dmem_we,
  input logic imem_re,
  input logic bad_op,
  input logic ld_we,
  input logic ar_we
);
  logic any_pulse;
  assign any_pulse = dmem_re || dmem_we || imem_re || bad_op;

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dmem_re, dmem_we, imem_re, bad_op}));

  // R6
  arwe_access_chk: assert property (@(posedge clk) disable iff (rst)
    ar_we |-> (dmem_re || dmem_we || imem_re));

  // R8
  ldwe_read_chk: assert property (@(posedge clk) disable iff (rst)
    ld_we |-> (dmem_re || imem_re));

  // R3
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (need_ext && !ext_valid) |=> (need_ext && !any_pulse));

  // R3
  wait_leave_chk: assert property (@(posedge clk) disable iff (rst)
    (need_ext && ext_valid) |=> !need_ext);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!need_ext && !op_valid) |=> !any_pulse);
endmodule

bind ldst_agen ldst_agen_chk u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .ext_valid(ext_valid),
  .need_ext(need_ext), .dmem_re(dmem_re), .dmem_we(dmem_we),
  .imem_re(imem_re), .bad_op(bad_op), .ld_we(ld_we), .ar_we(ar_we)
);

// File: tb/ldst_agen_tb.sv
module ldst_agen_tb;
  localparam int DW = 16;
  localparam int NAR = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic              op_valid = 1'b0, ext_valid = 1'b0;
  logic [15:0]       op_word = '0, ext_word = '0;
  logic [7:0]        page_lo = '0;
  logic [DW-1:0]     ar [NAR];
  logic [DW-1:0]     ix [NAR];
  logic [DW-1:0]     rf [32];
  logic [NAR*DW-1:0] ar_bus, ix_bus;
  logic [4:0]        src_sel, ld_reg;
  logic [DW-1:0]     src_data, mem_addr, mem_wdata, ar_next;
  logic              need_ext, dmem_re, dmem_we, imem_re, ld_we, ar_we, bad_op;
  logic [1:0]        ar_idx;

  always_comb begin
    for (int i = 0; i < NAR; i++) begin
      ar_bus[i*DW +: DW] = ar[i];
      ix_bus[i*DW +: DW] = ix[i];
    end
  end
  assign src_data = rf[src_sel];

  ldst_agen #(.DW(DW), .NAR(NAR)) u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_word(op_word),
    .ext_valid(ext_valid), .ext_word(ext_word), .page_lo(page_lo),
    .ar_bus(ar_bus), .ix_bus(ix_bus), .src_sel(src_sel), .src_data(src_data),
    .need_ext(need_ext), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .dmem_re(dmem_re), .dmem_we(dmem_we), .imem_re(imem_re), .ld_we(ld_we),
    .ld_reg(ld_reg), .ar_we(ar_we), .ar_idx(ar_idx), .ar_next(ar_next),
    .bad_op(bad_op)
  );

  int checks = 0, errors = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // independent reference: returns packed result and whether two words are needed
  function automatic logic [63:0] model(input logic [15:0] op, input logic [15:0] ext,
                                        output bit two);
    logic dre = 0, dwe = 0, ire = 0, bad = 0, lw = 0, aw = 0;
    logic [4:0] lr = 0; logic [1:0] ai = 0;
    logic [15:0] an = 0, ad = 0, wd = 0, base;
    logic [1:0] md = 0;
    bit ptr = 0;
    two = 0;
    casez (op)
      16'b0010_????_????_????: begin
        ad = {page_lo, op[7:0]};
        if (op[11]) begin dwe = 1; wd = rf[24 + op[10:8]]; end
        else begin dre = 1; lw = 1; lr = 5'(24 + op[10:8]); end
      end
      16'b0000_0000_11??_????: begin
        two = 1; ad = ext;
        if (op[5]) begin dwe = 1; wd = rf[op[4:0]]; end
        else begin dre = 1; lw = 1; lr = op[4:0]; end
      end
      16'b0001_0110_????_????: begin
        two = 1; dwe = 1; wd = ext; ad = 16'($signed(op[7:0]));
      end
      16'b0001_10??_????_????: begin
        ptr = 1; ai = op[6:5]; md = op[8:7]; ad = ar[op[6:5]];
        if (op[9]) begin dwe = 1; wd = rf[op[4:0]]; end
        else begin dre = 1; lw = 1; lr = op[4:0]; end
      end
      16'b0000_001?_0001_????: begin
        ptr = 1; ai = op[1:0]; md = op[3:2]; ad = ar[op[1:0]];
        ire = 1; lw = 1; lr = op[8] ? 5'd31 : 5'd30;
      end
      default: bad = 1;
    endcase
    if (ptr && md != 2'b00) begin
      base = ar[ai]; aw = 1;
      an = (md == 2'b01) ? base - 16'd1 : (md == 2'b10) ? base + 16'd1
         : 16'($signed(base) + $signed(ix[ai]));
    end else ai = 0;
    return {3'b0, dre, dwe, ire, bad, lw, lr, aw, ai, an, ad, wd};
  endfunction

  function automatic logic [63:0] observed();
    return {3'b0, dmem_re, dmem_we, imem_re, bad_op, ld_we, ld_reg, ar_we, ar_idx,
            ar_next, mem_addr, mem_wdata};
  endfunction

  task automatic run_op(input string req, input logic [15:0] op,
                        input logic [15:0] ext, input int stall);
    bit two;
    logic [63:0] exp = model(op, ext, two);
    @(negedge clk); op_valid = 1; op_word = op; ext_valid = 0;
    @(negedge clk); op_valid = 0;
    if (two) begin
      chk({req, " wait"}, {62'b0, need_ext, dmem_re | dmem_we | bad_op}, 64'b10);
      for (int s = 0; s < stall; s++) begin
        op_valid = 1; op_word = 16'h2000 ^ 16'(s);   // ignored while waiting (R10)
        @(negedge clk);
        chk({req, " stall R10"}, {62'b0, need_ext, dmem_re | dmem_we | bad_op}, 64'b10);
      end
      op_valid = 0; ext_valid = 1; ext_word = ext;
      @(negedge clk); ext_valid = 0;
    end
    chk(req, observed(), exp);
    @(negedge clk);
    chk({req, " pulse R10"}, {60'b0, dmem_re, dmem_we, imem_re, need_ext}, 64'b0);
  endtask

  task automatic t_reset();
    chk("R1 reset", {58'b0, dmem_re, dmem_we, imem_re, ld_we, ar_we, bad_op | need_ext}, 64'b0);
    @(negedge clk); rst = 0;
    @(negedge clk);
    chk("R1 after reset", {58'b0, dmem_re, dmem_we, imem_re, ld_we, ar_we, bad_op | need_ext}, 64'b0);
  endtask

  task automatic t_short();
    page_lo = 8'hA5; rf[27] = 16'hBEEF;
    run_op("R2 short load", 16'b0010_0101_0011_1100, 0, 0);
    run_op("R2 R11 short store", 16'b0010_1011_1111_0000, 0, 0);
  endtask

  task automatic t_long();
    rf[3] = 16'h1234;
    run_op("R3 long load", 16'h00D9, 16'hC0DE, 0);
    run_op("R3 R11 long store stall", 16'h00E3, 16'h8001, 3);
  endtask

  task automatic t_imm();
    run_op("R4 imm negative", 16'h1680, 16'h5A5A, 1);
    run_op("R4 imm positive", 16'h167F, 16'h0F0F, 0);
  endtask

  task automatic t_ind();
    ar[0] = 16'h0000; ar[1] = 16'hFFFF; ar[2] = 16'h0100; ar[3] = 16'h0010;
    ix[2] = 16'hFFF0; ix[3] = 16'h7FFF; rf[9] = 16'h4242;
    run_op("R5 ind none", 16'b000110_0_00_10_00111, 0, 0);
    run_op("R6 R7 dec wrap", 16'b000110_0_01_00_00001, 0, 0);
    run_op("R6 R7 inc wrap", 16'b000110_1_10_01_01001, 0, 0);
    run_op("R7 neg index", 16'b000110_1_11_10_01001, 0, 0);
    run_op("R7 pos index", 16'b000110_0_11_11_11111, 0, 0);
  endtask

  task automatic t_imem();
    run_op("R8 imem d0 inc", 16'b0000001_0_0001_10_11, 0, 0);
    run_op("R8 imem d1 idx", 16'b0000001_1_0001_11_10, 0, 0);
    run_op("R8 imem none", 16'b0000001_1_0001_00_01, 0, 0);
  endtask

  task automatic t_bad();
    run_op("R9 bad zero", 16'h0000, 0, 0);
    run_op("R9 bad near imem", 16'b0000001_0_0010_00_00, 0, 0);
    run_op("R9 bad high", 16'hFFFF, 0, 0);
  endtask

  task automatic t_random();
    logic [15:0] tmpl [6] = '{16'h2000, 16'h00C0, 16'h1600, 16'h1800, 16'h0210, 16'h0000};
    logic [15:0] mask [6] = '{16'h0FFF, 16'h003F, 16'h00FF, 16'h03FF, 16'h010F, 16'hFFFF};
    for (int n = 0; n < 200; n++) begin
      int k = $urandom_range(0, 5);
      for (int i = 0; i < NAR; i++) begin ar[i] = 16'($urandom); ix[i] = 16'($urandom); end
      for (int i = 0; i < 32; i++) rf[i] = 16'($urandom);
      page_lo = 8'($urandom);
      run_op("R2 R5 R6 R7 R8 R9 random", tmpl[k] | (16'($urandom) & mask[k]),
             16'($urandom), $urandom_range(0, 2));
    end
  endtask

  initial begin
    for (int i = 0; i < NAR; i++) begin ar[i] = '0; ix[i] = '0; end
    for (int i = 0; i < 32; i++) rf[i] = 16'(i * 16'h0111);
    @(negedge clk); @(negedge clk);
    t_reset();
    t_short();
    t_long();
    t_imm();
    t_ind();
    t_imem();
    t_bad();
    t_random();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule